// File: doc/BRIEF.md
# Quarter-Phase I2C Master Bit Engine

This block is the bit layer of an I2C master. A controller above it hands over one primitive at a time: a start condition, a stop condition, a byte to transmit, or a byte to receive. The engine plays that primitive out on the two open-drain bus wires as a fixed script of line states. A free-running divider splits every bit period into four equal quarters, and each quarter boundary moves at most one of the two wires. After a byte is sent, the engine reports whether the target acknowledged it. When a byte is received, the engine returns the byte and itself drives an acknowledge or not-acknowledge bit, as the caller chooses.

The caller offers a primitive with `cmd_valid` and a two-bit opcode. The engine takes it in any cycle in which `cmd_ready` is high, and drops `cmd_ready` until the last quarter of the script has run out. The engine drives the wires as pull-down enables, so a 1 on `scl_oe` or `sda_oe` pulls that wire low and a 0 releases it. The data wire is read back through `sda_in` and passes a two-flop synchronizer before it is used. The engine does not arbitrate between masters and does not wait for a target that holds the clock low.

The controller in `qbit_seq` steps through the phases IDLE, START, STOP, WBIT (one transmitted bit), WACK (the target's acknowledge slot), RBIT (one received bit) and RACK (the engine's own acknowledge slot). The transitions are these. IDLE moves to START, STOP, WBIT or RACK's partner RBIT when it accepts opcode 0, 1, 2 or 3. WBIT repeats for eight bits and then moves to WACK. RBIT repeats for eight bits and then moves to RACK. START, STOP, WACK and RACK each return to IDLE when their last quarter ends.

Top module: `i2c_qbit_engine`

## Requirements
- R1: After reset, both enables are 0 (wires released), `cmd_ready` is 1, and `nack` and `rd_byte` are 0.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. The opcodes are 0 = start, 1 = stop, 2 = write byte and 3 = read byte. `cmd_ready` then stays 0 for exactly 4 quarters for a start or a stop, 37 quarters for a write and 29 quarters for a read. A quarter is QUARTER_CYCLES clocks. `cmd_valid` pulses while busy are ignored.
- R3: A start first releases SDA, then releases SCL, then pulls SDA low while SCL is high, one step per quarter. It ends with SCL released and SDA pulled low. This also holds when it begins with SCL low (repeated start).
- R4: A stop pulls SCL low, then pulls SDA low, then releases SCL, then releases SDA while SCL is high, one step per quarter. It ends with both wires released.
- R5: A write shifts `wr_byte` out MSB first, with eight SCL high pulses. Within a byte, SDA changes only while SCL is low, exactly one quarter after SCL falls.
- R6: After the eighth bit of a write, SDA is released for a ninth SCL pulse and sampled after two quarters of SCL high. `nack` becomes 0 if the wire was low and 1 if it was high. The write ends with SCL pulled low.
- R7: A read releases SDA and samples each bit one quarter after SCL rises, MSB first. SCL stays high one further quarter. The assembled byte appears on `rd_byte`.
- R8: After a read byte, a ninth SCL pulse carries the engine's acknowledge. `ack_sel` = 0 pulls SDA low (acknowledge, continue). `ack_sel` = 1 leaves SDA released (end of read).
- R9: SCL and SDA enables never change on the same clock edge.
- R10: `nack` changes only during a write and `rd_byte` changes only during a read. Both hold their values across idle cycles and across other commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted this cycle if valid |
| cmd_op | input | 2 | 0 start, 1 stop, 2 write byte, 3 read byte |
| wr_byte | input | 8 | Byte to transmit, captured on acceptance |
| ack_sel | input | 1 | Acknowledge level to send after a read (0 ack, 1 nack) |
| rd_byte | output | 8 | Last received byte |
| nack | output | 1 | Acknowledge level sampled after the last write |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level of the SDA wire |

## Verification
A behavioural bus target watches SCL edges. It answers writes with an acknowledge or a not-acknowledge and drives read data bit by bit. Writes use 0xA5, 0x3C, 0x91, 0x00, 0xFF and 0x0F. Their alternating, grouped and solid bit runs separate a correct MSB-first shift from a reversed or stuck one, and also check that SDA moves exactly one quarter after each SCL fall. Reads of 0xC6 with acknowledge and 0x5A with not-acknowledge separate the sampling of the target's bits from the engine's own acknowledge bit. A repeated start from SCL low and busy-time command pulses check the handshake and the start script beyond the plain path.

// File: rtl/i2c_qbit_pkg.sv
package i2c_qbit_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_STOP,
        S_WBIT,
        S_WACK,
        S_RBIT,
        S_RACK
    } phase_e;

    localparam int BITS   = 8;
    localparam int BIT_W  = $clog2(BITS);
    localparam int SLOT_W = 3;

    // quarter slot in which the sampled SDA is taken (at its closing tick)
    localparam logic [SLOT_W-1:0] WACK_SAMPLE_SLOT = 3'd3;
    localparam logic [SLOT_W-1:0] RBIT_SAMPLE_SLOT = 3'd1;

    function automatic logic [SLOT_W-1:0] last_slot(input phase_e p);
        case (p)
            S_START, S_STOP, S_WBIT: last_slot = 3'd3;
            S_WACK, S_RACK:          last_slot = 3'd4;
            S_RBIT:                  last_slot = 3'd2;
            default:                 last_slot = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/qtick_gen.sv
module qtick_gen #(
    parameter int QUARTER_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sda_sync.sv
module sda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) ff <= '1;
                else        ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) ff <= '1;
                else        ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/qbit_seq.sv
module qbit_seq
    import i2c_qbit_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [BITS-1:0]     wr_byte,
    input  logic                ack_sel,
    input  logic                sda_s,
    output logic                cmd_ready,
    output logic                run,
    output logic                scl_low,
    output logic                sda_low,
    output logic [BITS-1:0]     rd_byte,
    output logic                nack
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

    phase_e            st, st_n;
    logic [SLOT_W-1:0] slot, slot_n;
    logic [BIT_W-1:0]  bitn, bitn_n;
    logic              adv;
    logic              accept;
    logic [BITS-1:0]   wsh;
    logic [BITS-1:0]   rsh;
    logic              ackr;
    logic              scl_n, sda_n;
    logic              wr_bit_low;

    assign cmd_ready  = (st == S_IDLE);
    assign run        = (st != S_IDLE);
    assign accept     = cmd_valid && cmd_ready;
    assign wr_bit_low = !wsh[BITS-1];

    // next phase, slot and bit
    always_comb begin
        st_n   = st;
        slot_n = slot;
        bitn_n = bitn;
        adv    = 1'b0;
        if (st == S_IDLE) begin
            if (cmd_valid) begin
                adv    = 1'b1;
                slot_n = '0;
                bitn_n = '0;
                unique case (op_e'(cmd_op))
                    OP_START: st_n = S_START;
                    OP_STOP:  st_n = S_STOP;
                    OP_WRITE: st_n = S_WBIT;
                    OP_READ:  st_n = S_RBIT;
                endcase
            end
        end else if (tick) begin
            adv = 1'b1;
            if (slot == last_slot(st)) begin
                slot_n = '0;
                case (st)
                    S_WBIT: begin
                        if (bitn == LAST_BIT) st_n = S_WACK;
                        else                  bitn_n = bitn + 1'b1;
                    end
                    S_RBIT: begin
                        if (bitn == LAST_BIT) st_n = S_RACK;
                        else                  bitn_n = bitn + 1'b1;
                    end
                    default: st_n = S_IDLE;
                endcase
            end else begin
                slot_n = slot + 1'b1;
            end
        end
    end

    // line script: pull-down levels for the slot being entered
    always_comb begin
        scl_n = scl_low;
        sda_n = sda_low;
        if (adv) begin
            unique case (st_n)
                S_IDLE: begin
                end
                S_START: begin
                    case (slot_n)
                        3'd0:    begin end
                        3'd1:    begin sda_n = 1'b0; end
                        3'd2:    begin scl_n = 1'b0; sda_n = 1'b0; end
                        default: begin scl_n = 1'b0; sda_n = 1'b1; end
                    endcase
                end
                S_STOP: begin
                    case (slot_n)
                        3'd0:    begin scl_n = 1'b1; end
                        3'd1:    begin scl_n = 1'b1; sda_n = 1'b1; end
                        3'd2:    begin scl_n = 1'b0; sda_n = 1'b1; end
                        default: begin scl_n = 1'b0; sda_n = 1'b0; end
                    endcase
                end
                S_WBIT: begin
                    case (slot_n)
                        3'd0:    begin scl_n = 1'b1; end
                        3'd1:    begin scl_n = 1'b1; sda_n = wr_bit_low; end
                        default: begin scl_n = 1'b0; sda_n = wr_bit_low; end
                    endcase
                end
                S_WACK: begin
                    case (slot_n)
                        3'd0:       begin scl_n = 1'b1; end
                        3'd1:       begin scl_n = 1'b1; sda_n = 1'b0; end
                        3'd2, 3'd3: begin scl_n = 1'b0; sda_n = 1'b0; end
                        default:    begin scl_n = 1'b1; sda_n = 1'b0; end
                    endcase
                end
                S_RBIT: begin
                    case (slot_n)
                        3'd0:    begin scl_n = 1'b1; sda_n = 1'b0; end
                        default: begin scl_n = 1'b0; sda_n = 1'b0; end
                    endcase
                end
                S_RACK: begin
                    case (slot_n)
                        3'd0:       begin scl_n = 1'b1; end
                        3'd1:       begin scl_n = 1'b1; sda_n = !ackr; end
                        3'd2, 3'd3: begin scl_n = 1'b0; sda_n = !ackr; end
                        default:    begin scl_n = 1'b1; sda_n = !ackr; end
                    endcase
                end
                default: begin
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            slot <= '0;
            bitn <= '0;
        end else begin
            st   <= st_n;
            slot <= slot_n;
            bitn <= bitn_n;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_low <= 1'b0;
            sda_low <= 1'b0;
            wsh     <= '0;
            rsh     <= '0;
            ackr    <= 1'b0;
            nack    <= 1'b0;
            rd_byte <= '0;
        end else begin
            scl_low <= scl_n;
            sda_low <= sda_n;
            if (accept) begin
                wsh  <= wr_byte;
                ackr <= ack_sel;
            end
            if (tick && st == S_WBIT && slot == last_slot(S_WBIT)) begin
                wsh <= {wsh[BITS-2:0], 1'b0};
            end
            if (tick && st == S_WACK && slot == WACK_SAMPLE_SLOT) begin
                nack <= sda_s;
            end
            if (tick && st == S_RBIT && slot == RBIT_SAMPLE_SLOT) begin
                rsh <= {rsh[BITS-2:0], sda_s};
                if (bitn == LAST_BIT) begin
                    rd_byte <= {rsh[BITS-2:0], sda_s};
                end
            end
        end
    end
endmodule

// File: rtl/i2c_qbit_engine.sv
module i2c_qbit_engine #(
    parameter int QUARTER_CYCLES = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_op,
    input  logic [7:0] wr_byte,
    input  logic       ack_sel,
    output logic [7:0] rd_byte,
    output logic       nack,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    logic tick;
    logic run;
    logic sda_s;

    qtick_gen #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sda_in),
        .q     (sda_s)
    );

    qbit_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .wr_byte   (wr_byte),
        .ack_sel   (ack_sel),
        .sda_s     (sda_s),
        .cmd_ready (cmd_ready),
        .run       (run),
        .scl_low   (scl_oe),
        .sda_low   (sda_oe),
        .rd_byte   (rd_byte),
        .nack      (nack)
    );
endmodule

// File: rtl/i2c_qbit_checker.sv
module i2c_qbit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] rd_byte,
    input logic       nack,
    input logic       scl_oe,
    input logic       sda_oe
);
    // R2: acceptance makes the engine busy on the next cycle
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R2: wires move only while a script runs or as one is accepted
    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(scl_oe) || !$stable(sda_oe)) |-> $past(!cmd_ready || cmd_valid));

    // R9: the two enables never switch on the same edge
    a_r9_lines_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe) |-> $stable(sda_oe));

    // R10: results hold across an idle cycle
    a_r10_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid) |=> ($stable(nack) && $stable(rd_byte)));
endmodule

bind i2c_qbit_engine i2c_qbit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rd_byte   (rd_byte),
    .nack      (nack),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
);

// File: tb/test_i2c_qbit_engine.sv
`timescale 1ns/1ps
module test_i2c_qbit_engine;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] wr_byte = 8'h00;
    logic       ack_sel = 1'b0;
    logic [7:0] rd_byte;
    logic       nack;
    logic       scl_oe;
    logic       sda_oe;
    logic       sda_in;
    logic       slave_low = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    // bus monitor / target model state
    int         mode = 0;       // 0 none, 1 target of write, 2 source of read
    logic [7:0] sdat = 8'h00;
    logic       sack = 1'b0;
    int         rises = 0;
    int         starts = 0;
    int         stops = 0;
    int         timing_err = 0;
    int         since_fall = 0;
    logic [8:0] bitlog = '0;
    logic       p_scl, p_sda, p_sda_oe;
    logic       scl_l, sda_l;

    always #4 clk = ~clk;

    assign sda_in = !(sda_oe || slave_low);

    i2c_qbit_engine #(.QUARTER_CYCLES(Q), .SYNC_STAGES(2)) i_i2c_qbit_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .wr_byte(wr_byte), .ack_sel(ack_sel), .rd_byte(rd_byte),
        .nack(nack), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    always @(negedge clk) begin
        scl_l = !scl_oe;
        sda_l = !(sda_oe || slave_low);
        if (!rst_n) begin
            p_scl = 1'b1; p_sda = 1'b1; p_sda_oe = 1'b0; since_fall = 0;
        end else begin
            if (scl_l && !p_scl) begin
                bitlog = {bitlog[7:0], sda_l};
                rises  = rises + 1;
            end
            if (!scl_l && p_scl) begin
                since_fall = 0;
                if (mode == 1) begin
                    if (rises == 8)      slave_low = sack;
                    else if (rises == 9) slave_low = 1'b0;
                end else if (mode == 2) begin
                    if (rises >= 1 && rises <= 7) slave_low = !sdat[7-rises];
                    else if (rises == 8)          slave_low = 1'b0;
                end
            end else if (since_fall < 100000) begin
                since_fall = since_fall + 1;
            end
            if (scl_l && p_scl && p_sda && !sda_l) starts = starts + 1;
            if (scl_l && p_scl && !p_sda && sda_l) stops = stops + 1;
            if (mode == 1 && rises >= 1 && sda_oe != p_sda_oe) begin
                if (scl_l || since_fall != Q) timing_err = timing_err + 1;
            end
            p_scl = scl_l;
            p_sda = !(sda_oe || slave_low);
            p_sda_oe = sda_oe;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] wd,
                           input logic ak, input bit poke, output int dur);
        @(negedge clk); #1;
        cmd_op = op; wr_byte = wd; ack_sel = ak; cmd_valid = 1'b1;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        dur = 0;
        while (!cmd_ready) begin
            dur++;
            if (poke && dur == 2) begin cmd_valid = 1'b1; cmd_op = 2'd1; end
            if (poke && dur == 6) cmd_valid = 1'b0;
            @(negedge clk); #1;
        end
    endtask

    task automatic t_reset();
        check(scl_oe == 1'b0, "R1", "scl_oe after reset", scl_oe, 0);
        check(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
        check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
        check(nack == 1'b0, "R1", "nack after reset", nack, 0);
        check(rd_byte == 8'h00, "R1", "rd_byte after reset", rd_byte, 0);
    endtask

    task automatic t_start();
        int dur; int s0; logic [7:0] rd0; logic nk0;
        s0 = starts; rd0 = rd_byte; nk0 = nack;
        run_cmd(2'd0, 8'h00, 1'b0, 1'b0, dur);
        check(dur == 4*Q, "R2", "start busy cycles", dur, 4*Q);
        check(starts == s0 + 1, "R3", "start condition count", starts, s0 + 1);
        check(scl_oe == 1'b0 && sda_oe == 1'b1, "R3", "lines after start",
              {scl_oe, sda_oe}, 1);
        check(rd_byte == rd0 && nack == nk0, "R10", "results across start",
              {rd_byte, nack}, {rd0, nk0});
    endtask

    task automatic t_stop();
        int dur; int s0;
        s0 = stops;
        run_cmd(2'd1, 8'h00, 1'b0, 1'b0, dur);
        check(dur == 4*Q, "R2", "stop busy cycles", dur, 4*Q);
        check(stops == s0 + 1, "R4", "stop condition count", stops, s0 + 1);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R4", "lines after stop",
              {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_write(input logic [7:0] d, input logic tgt_ack, input bit poke);
        int dur; int te0; int st0; logic [7:0] rd0;
        te0 = timing_err; st0 = stops; rd0 = rd_byte;
        @(negedge clk); #1;
        mode = 1; sack = tgt_ack; rises = 0;
        run_cmd(2'd2, d, 1'b0, poke, dur);
        mode = 0;
        check(dur == 37*Q, poke ? "R2" : "R2", "write busy cycles", dur, 37*Q);
        check(stops == st0, "R2", "no stop during write", stops, st0);
        check(rises == 9, "R5", "write clock pulses", rises, 9);
        check(bitlog[8:1] == d, "R5", "bits on bus", bitlog[8:1], d);
        check(timing_err == te0, "R5", "sda change placement errors", timing_err, te0);
        check(bitlog[0] == !tgt_ack, "R6", "ninth bit level", bitlog[0], !tgt_ack);
        check(nack == !tgt_ack, "R6", "nack output", nack, !tgt_ack);
        check(scl_oe == 1'b1, "R6", "scl held low after write", scl_oe, 1);
        check(rd_byte == rd0, "R10", "rd_byte across write", rd_byte, rd0);
    endtask

    task automatic t_read(input logic [7:0] d, input logic ak);
        int dur; logic nk0;
        nk0 = nack;
        @(negedge clk); #1;
        mode = 2; sdat = d; rises = 0; slave_low = !d[7];
        run_cmd(2'd3, 8'h00, ak, 1'b0, dur);
        mode = 0;
        check(dur == 29*Q, "R2", "read busy cycles", dur, 29*Q);
        check(rd_byte == d, "R7", "rd_byte", rd_byte, d);
        check(bitlog[8:1] == d, "R7", "bits on bus", bitlog[8:1], d);
        check(bitlog[0] == ak, "R8", "master acknowledge level", bitlog[0], ak);
        check(sda_oe == !ak, "R8", "sda drive after read", sda_oe, !ak);
        check(nack == nk0, "R10", "nack across read", nack, nk0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_start();
        t_write(8'hA5, 1'b1, 1'b0);
        t_write(8'h3C, 1'b0, 1'b0);
        t_start();                       // repeated start from SCL low
        t_write(8'h91, 1'b1, 1'b0);
        t_read(8'hC6, 1'b0);
        t_read(8'h5A, 1'b1);
        t_stop();
        t_start();
        t_write(8'h00, 1'b1, 1'b0);
        t_write(8'hFF, 1'b0, 1'b0);
        t_write(8'h0F, 1'b1, 1'b1);      // R2: pulses while busy are ignored
        t_stop();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule